// File: doc/BRIEF.md
# Address-Folded Parity Load/Store Guard

This block sits on the path between a processor core and its data cache. On a store, it derives one check bit per byte lane and sends the check bits to the cache together with the write data. Each check bit mixes the lane's data parity with one bit of a short fold of the word address. On a load, it recomputes the check bits from the returned data and the address the core asked for. It then compares them with the check bits the cache returned. Any difference is an error.

The address takes part only through the check bits, so the cache needs no extra storage. Two kinds of fault become visible. One is a flipped bit in a stored word or in its check bits. The other is a cache that returns the word belonging to some other address, when the two address folds differ. Requests and responses pass through combinationally, so the block adds no latency.

The cache returns load responses in request order. A small queue keeps the addresses of outstanding loads, so every error report carries the address that was actually requested. Address arithmetic, alignment and stores that never reach the array are handled elsewhere.

Top module: `addr_parity_guard`

## Requirements
- R1: For every store, `cache_req_wchk[i]` equals the XOR of the eight bits of data lane i (bits 8i+7..8i) with bit i of the address fold. The fold is computed as follows. Zero-pad the word address to a multiple of the lane count NB. Cut it into NB-bit chunks starting from bit 0. XOR the chunks together. Equivalently, fold bit k is the XOR of every address bit b with b mod NB = k.
- R2: `cache_req_valid`, `cache_req_write`, `cache_req_addr`, `cache_req_be` and `cache_req_wdata` equal the matching core request fields in the same cycle.
- R3: `core_rsp_valid` and `core_rsp_rdata` equal `cache_rsp_valid` and `cache_rsp_rdata` in the same cycle. A response whose check bits agree with the recomputation leaves `err_valid` low.
- R4: In the cycle a response returns, set bit i of `err_lanes` when the recomputed check bit i differs from `cache_rsp_rchk[i]`. Raise `err_valid` in that same cycle exactly when any lane differs. Consequently, a single flipped bit in data lane k, or in check bit k, gives `err_lanes` = 1 << k.
- R5: If data stored under address B is returned for a load of address A, report an error with `err_lanes` equal to fold(A) XOR fold(B).
- R6: On a partial store, forward `cache_req_be` unchanged and generate the check bit of every enabled lane by R1. A later full-word read of the merged word raises no error.
- R7: Responses pair with loads in issue order. On an error, `err_addr` gives the address of the oldest outstanding load. A load may be issued in the same cycle that a response retires. Up to TAG_DEPTH loads may be outstanding.
- R8: While reset is active, `err_valid` stays low even for a corrupted response. Reset discards every outstanding load address.
- R9: Reading data from an address whose fold equals that of the requested address raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core access request |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | ADDR_W | Word address |
| core_req_be | input | DATA_W/8 | Byte-lane enables for stores |
| core_req_wdata | input | DATA_W | Store data |
| core_rsp_valid | output | 1 | Load response to core |
| core_rsp_rdata | output | DATA_W | Load data to core |
| cache_req_valid | output | 1 | Request to cache |
| cache_req_write | output | 1 | Store flag to cache |
| cache_req_addr | output | ADDR_W | Address to cache |
| cache_req_be | output | DATA_W/8 | Lane enables to cache |
| cache_req_wdata | output | DATA_W | Write data to cache |
| cache_req_wchk | output | DATA_W/8 | Check bits to store |
| cache_rsp_valid | input | 1 | Load response from cache |
| cache_rsp_rdata | input | DATA_W | Returned data |
| cache_rsp_rchk | input | DATA_W/8 | Returned check bits |
| err_valid | output | 1 | Error pulse |
| err_addr | output | ADDR_W | Requested address of the failing load |
| err_lanes | output | DATA_W/8 | Lanes whose check bit mismatched |

## Verification
The bench builds the block with a 14-bit address, 32-bit data and a tag queue four deep. Because 14 is not a multiple of the four-lane fold width, the top address chunk is zero-padded, and a fault in the top address bit shows up in fold bit 1. The depth of four lets the bench fill the queue completely, retire a response while issuing a new load in the same cycle, and pick out the tag of a failing load in the middle of the queue. The chosen addresses give a fold difference in bit 0, a difference in the padded chunk, and a pair whose folds cancel.

// File: rtl/apg_pkg.sv
package apg_pkg;

  // Width of one protected byte lane
  localparam int unsigned LANE_W = 8;

  // Number of lanes in a data word
  function automatic int unsigned lane_count(input int unsigned data_w);
    return (data_w + LANE_W - 1) / LANE_W;
  endfunction

endpackage

// File: rtl/apg_addr_fold.sv
module apg_addr_fold #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned FOLD_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [FOLD_W-1:0] fold
);

  localparam int unsigned NCHUNK = (ADDR_W + FOLD_W - 1) / FOLD_W;
  localparam int unsigned PAD_W  = NCHUNK * FOLD_W;

  logic [PAD_W-1:0]              padded;
  logic [NCHUNK:0][FOLD_W-1:0]   acc;

  // Zero-extend so the last chunk is complete
  always_comb begin
    padded               = '0;
    padded[ADDR_W-1:0]   = addr;
  end

  assign acc[0] = '0;

  // XOR chain across the address chunks
  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign acc[c+1] = acc[c] ^ padded[c*FOLD_W +: FOLD_W];
  end

  assign fold = acc[NCHUNK];

endmodule

// File: rtl/apg_lane_parity.sv
module apg_lane_parity
  import apg_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic [NB*LANE_W-1:0] data,
  input  logic [NB-1:0]        fold,
  output logic [NB-1:0]        chk
);

  // One check bit per lane: lane parity mixed with one fold bit
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign chk[i] = (^data[i*LANE_W +: LANE_W]) ^ fold[i];
  end

endmodule

// File: rtl/apg_tag_fifo.sv
module apg_tag_fifo #(
  parameter int unsigned TAG_W = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop,
  output logic [TAG_W-1:0] head_tag,
  output logic             empty,
  output logic             full
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [TAG_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == FULL_CNT);
  assign do_pop   = pop & ~empty;
  assign do_push  = push & (~full | do_pop);
  assign head_tag = slot_q[rd_q];

  // Next-state logic
  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    unique case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Tag storage, write-enabled, no reset
  always_ff @(posedge clk) begin
    if (do_push) begin
      slot_q[wr_q] <= push_tag;
    end
  end

  AST_TAG_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full) else $error("tag queue overflow"); // R7

  AST_TAG_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty) else $error("pushed tag lost"); // R7

  AST_TAG_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !empty) |=> $stable(head_tag)) else $error("head tag moved"); // R7

endmodule

// File: rtl/addr_parity_guard.sv
module addr_parity_guard
  import apg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TAG_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         core_req_valid,
  input  logic                         core_req_write,
  input  logic [ADDR_W-1:0]            core_req_addr,
  input  logic [DATA_W/LANE_W-1:0]     core_req_be,
  input  logic [DATA_W-1:0]            core_req_wdata,
  output logic                         core_rsp_valid,
  output logic [DATA_W-1:0]            core_rsp_rdata,
  output logic                         cache_req_valid,
  output logic                         cache_req_write,
  output logic [ADDR_W-1:0]            cache_req_addr,
  output logic [DATA_W/LANE_W-1:0]     cache_req_be,
  output logic [DATA_W-1:0]            cache_req_wdata,
  output logic [DATA_W/LANE_W-1:0]     cache_req_wchk,
  input  logic                         cache_rsp_valid,
  input  logic [DATA_W-1:0]            cache_rsp_rdata,
  input  logic [DATA_W/LANE_W-1:0]     cache_rsp_rchk,
  output logic                         err_valid,
  output logic [ADDR_W-1:0]            err_addr,
  output logic [DATA_W/LANE_W-1:0]     err_lanes
);

  localparam int unsigned NB = lane_count(DATA_W);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q, rsync_d;
  logic       rst_sync_n;

  assign rsync_d = {rsync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= rsync_d;
  end

  assign rst_sync_n = rsync_q[1];

  // Request path: straight through, plus check bits
  logic [NB-1:0] st_fold;

  assign cache_req_valid = core_req_valid;
  assign cache_req_write = core_req_write;
  assign cache_req_addr  = core_req_addr;
  assign cache_req_be    = core_req_be;
  assign cache_req_wdata = core_req_wdata;

  apg_addr_fold #(.ADDR_W(ADDR_W), .FOLD_W(NB)) i_st_fold (
    .addr (core_req_addr),
    .fold (st_fold)
  );

  apg_lane_parity #(.NB(NB)) i_st_par (
    .data (core_req_wdata),
    .fold (st_fold),
    .chk  (cache_req_wchk)
  );

  // Outstanding load addresses, oldest at the head
  logic              tag_push, tag_pop, tag_empty, tag_full;
  logic [ADDR_W-1:0] tag_head;

  assign tag_push = core_req_valid & ~core_req_write;
  assign tag_pop  = cache_rsp_valid;

  apg_tag_fifo #(.TAG_W(ADDR_W), .DEPTH(TAG_DEPTH)) i_tags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (tag_push),
    .push_tag (core_req_addr),
    .pop      (tag_pop),
    .head_tag (tag_head),
    .empty    (tag_empty),
    .full     (tag_full)
  );

  // Response path: recompute against the requested address
  logic [NB-1:0] ld_fold, ld_chk, mism;
  logic          any_mism;

  apg_addr_fold #(.ADDR_W(ADDR_W), .FOLD_W(NB)) i_ld_fold (
    .addr (tag_head),
    .fold (ld_fold)
  );

  apg_lane_parity #(.NB(NB)) i_ld_par (
    .data (cache_rsp_rdata),
    .fold (ld_fold),
    .chk  (ld_chk)
  );

  assign mism     = ld_chk ^ cache_rsp_rchk;
  assign any_mism = |mism;

  assign core_rsp_valid = cache_rsp_valid;
  assign core_rsp_rdata = cache_rsp_rdata;

  always_comb begin
    err_valid = rst_sync_n & cache_rsp_valid & any_mism;
    err_addr  = err_valid ? tag_head : '0;
    err_lanes = err_valid ? mism     : '0;
  end

  AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_valid |-> core_rsp_valid) else $error("error without response"); // R4

  AST_RSP_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cache_rsp_valid |-> !tag_empty) else $error("response with no outstanding load"); // R7

  AST_LOAD_ROOM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tag_push && tag_full) |-> tag_pop) else $error("too many outstanding loads"); // R7

endmodule

// File: tb/test_addr_parity_guard.sv
`timescale 1ns/1ps
module test_addr_parity_guard;

  localparam int AW = 14;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          core_req_valid, core_req_write;
  logic [AW-1:0] core_req_addr;
  logic [NB-1:0] core_req_be;
  logic [DW-1:0] core_req_wdata;
  logic          core_rsp_valid;
  logic [DW-1:0] core_rsp_rdata;
  logic          cache_req_valid, cache_req_write;
  logic [AW-1:0] cache_req_addr;
  logic [NB-1:0] cache_req_be, cache_req_wchk;
  logic [DW-1:0] cache_req_wdata;
  logic          cache_rsp_valid;
  logic [DW-1:0] cache_rsp_rdata;
  logic [NB-1:0] cache_rsp_rchk;
  logic          err_valid;
  logic [AW-1:0] err_addr;
  logic [NB-1:0] err_lanes;

  addr_parity_guard #(.ADDR_W(AW), .DATA_W(DW), .TAG_DEPTH(DEPTH)) i_addr_parity_guard (
    .clk, .rst_n,
    .core_req_valid, .core_req_write, .core_req_addr, .core_req_be, .core_req_wdata,
    .core_rsp_valid, .core_rsp_rdata,
    .cache_req_valid, .cache_req_write, .cache_req_addr, .cache_req_be,
    .cache_req_wdata, .cache_req_wchk,
    .cache_rsp_valid, .cache_rsp_rdata, .cache_rsp_rchk,
    .err_valid, .err_addr, .err_lanes
  );

  int n_vec = 0;
  int n_bad = 0;
  bit run_model = 1'b0;
  logic [AW-1:0] tagq [$];
  logic [DW-1:0] cdata [int];
  logic [NB-1:0] cchk  [int];

  function automatic logic [NB-1:0] ref_fold(input logic [AW-1:0] a);
    logic [NB-1:0] f = '0;
    for (int b = 0; b < AW; b++) f[b % NB] ^= a[b];
    return f;
  endfunction

  function automatic logic [NB-1:0] ref_chk(input logic [DW-1:0] d, input logic [AW-1:0] a);
    logic [NB-1:0] f = ref_fold(a);
    logic [NB-1:0] c;
    for (int i = 0; i < NB; i++) c[i] = (^d[8*i +: 8]) ^ f[i];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model, compared every clock at the falling edge
  always @(negedge clk) begin
    if (run_model) begin
      logic [NB-1:0] lanes;
      check(cache_req_valid == core_req_valid, "R2", "valid forward", 64'(cache_req_valid), 64'(core_req_valid));
      if (core_req_valid) begin
        check({cache_req_write, cache_req_addr, cache_req_be, cache_req_wdata} ==
              {core_req_write, core_req_addr, core_req_be, core_req_wdata},
              "R2", "request forward", 64'(cache_req_addr), 64'(core_req_addr));
        if (core_req_write)
          check(cache_req_wchk == ref_chk(core_req_wdata, core_req_addr), "R1", "store check bits",
                64'(cache_req_wchk), 64'(ref_chk(core_req_wdata, core_req_addr)));
      end
      check(core_rsp_valid == cache_rsp_valid && (!cache_rsp_valid || core_rsp_rdata == cache_rsp_rdata),
            "R3", "response forward", 64'(core_rsp_rdata), 64'(cache_rsp_rdata));
      if (cache_rsp_valid) begin
        if (tagq.size() == 0) begin
          check(1'b0, "R7", "response without load", 64'(0), 64'(1));
        end else begin
          lanes = ref_chk(cache_rsp_rdata, tagq[0]) ^ cache_rsp_rchk;
          check(err_valid == (lanes != '0), "R4", "error flag", 64'(err_valid), 64'(lanes != '0));
          if (lanes != '0) begin
            check(err_addr == tagq[0], "R7", "error address", 64'(err_addr), 64'(tagq[0]));
            check(err_lanes == lanes, "R4", "error lanes", 64'(err_lanes), 64'(lanes));
          end
          void'(tagq.pop_front());
        end
      end else begin
        check(err_valid == 1'b0, "R3", "idle error flag", 64'(err_valid), 64'(0));
      end
      if (core_req_valid && !core_req_write) tagq.push_back(core_req_addr);
    end
  end

  task automatic drive(input bit rv, input bit rw, input logic [AW-1:0] a, input logic [NB-1:0] be,
                       input logic [DW-1:0] wd, input bit sv, input logic [DW-1:0] sd,
                       input logic [NB-1:0] sc);
    @(posedge clk);
    #1;
    core_req_valid  = rv;
    core_req_write  = rw;
    core_req_addr   = a;
    core_req_be     = be;
    core_req_wdata  = wd;
    cache_rsp_valid = sv;
    cache_rsp_rdata = sd;
    cache_rsp_rchk  = sc;
  endtask

  task automatic idle();
    drive(0, 0, '0, '0, '0, 0, '0, '0);
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [DW-1:0] wd);
    logic [NB-1:0] c = ref_chk(wd, a);
    drive(1, 1, a, be, wd, 0, '0, '0);
    if (!cdata.exists(int'(a))) begin
      cdata[int'(a)] = '0;
      cchk[int'(a)]  = ref_chk('0, a);
    end
    for (int i = 0; i < NB; i++) begin
      if (be[i]) begin
        cdata[int'(a)][8*i +: 8] = wd[8*i +: 8];
        cchk[int'(a)][i]         = c[i];
      end
    end
  endtask

  task automatic load(input logic [AW-1:0] a);
    drive(1, 0, a, '1, '0, 0, '0, '0);
  endtask

  // Respond with the word stored at src, optionally corrupted; optional new load alongside
  task automatic resp(input bit ldv, input logic [AW-1:0] lda, input logic [AW-1:0] src,
                      input logic [DW-1:0] dflip, input logic [NB-1:0] cflip,
                      input bit exp_err, input logic [NB-1:0] exp_l, input logic [AW-1:0] exp_a,
                      input string req);
    drive(ldv, 1'b0, lda, '1, '0, 1, cdata[int'(src)] ^ dflip, cchk[int'(src)] ^ cflip);
    @(negedge clk);
    check(err_valid == exp_err, req, "directed error flag", 64'(err_valid), 64'(exp_err));
    if (exp_err)
      check(err_lanes == exp_l && err_addr == exp_a, req, "directed lanes/address",
            {32'(err_lanes), 32'(err_addr)}, {32'(exp_l), 32'(exp_a)});
  endtask

  localparam logic [AW-1:0] A0 = 14'h0123;
  localparam logic [AW-1:0] A1 = 14'h0122;  // fold differs in bit 0
  localparam logic [AW-1:0] A2 = 14'h0132;  // same fold as A0
  localparam logic [AW-1:0] A3 = 14'h2123;  // differs in padded top chunk, fold bit 1
  localparam logic [AW-1:0] A4 = 14'h1A5C;

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    core_req_valid = 0; core_req_write = 0; core_req_addr = '0; core_req_be = '0;
    core_req_wdata = '0; cache_rsp_valid = 0; cache_rsp_rdata = '0; cache_rsp_rchk = '0;

    // R8: corrupted response during reset raises nothing
    drive(0, 0, '0, '0, '0, 1, 32'h0000_0001, 4'b0000);
    @(negedge clk);
    check(err_valid == 1'b0, "R8", "error during reset", 64'(err_valid), 64'(0));
    idle();
    @(negedge clk);
    check(err_valid == 1'b0 && core_rsp_valid == 1'b0, "R8", "reset outputs",
          64'({err_valid, core_rsp_valid}), 64'(0));
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) idle();
    run_model = 1'b1;

    // R1/R2: full stores
    store(A0, 4'hF, 32'hDEAD_BEEF);
    store(A1, 4'hF, 32'hDEAD_BEEF);
    store(A2, 4'hF, 32'hDEAD_BEEF);
    store(A3, 4'hF, 32'hDEAD_BEEF);
    store(A4, 4'hF, 32'h5A3C_96F0);

    // R3: clean loads
    load(A0); resp(0, '0, A0, '0, '0, 0, '0, '0, "R3");
    load(A4); resp(0, '0, A4, '0, '0, 0, '0, '0, "R3");

    // R4: single-bit flips in data and check bits
    for (int k = 0; k < NB; k++) begin
      load(A4);
      resp(0, '0, A4, 32'(1) << (8*k + 3), '0, 1, 4'(1 << k), A4, "R4");
      load(A4);
      resp(0, '0, A4, '0, 4'(1 << k), 1, 4'(1 << k), A4, "R4");
    end

    // R5: wrong-location returns; R9: equal folds alias
    load(A0); resp(0, '0, A1, '0, '0, 1, 4'b0001, A0, "R5");
    load(A0); resp(0, '0, A3, '0, '0, 1, 4'b0010, A0, "R5");
    load(A0); resp(0, '0, A2, '0, '0, 0, '0, '0, "R9");

    // R7: full queue, ordered tags, overlapped issue and retire
    load(A0); load(A3); load(A4); load(A1);
    resp(0, '0, A0, '0, '0, 0, '0, '0, "R7");
    resp(0, '0, A3, '0, '0, 0, '0, '0, "R7");
    resp(0, '0, A4, 32'(1) << 21, '0, 1, 4'b0100, A4, "R7");
    resp(1, A2, A1, '0, '0, 0, '0, '0, "R7");
    resp(0, '0, A2, 32'(1) << 30, '0, 1, 4'b1000, A2, "R7");

    // R6: partial stores merge and read back clean
    store(A4, 4'b0101, 32'h1122_3344);
    load(A4); resp(0, '0, A4, '0, '0, 0, '0, '0, "R6");
    check(core_rsp_rdata == 32'h5A22_9644, "R6", "merged word", 64'(core_rsp_rdata), 64'h5A22_9644);
    store(A4, 4'b1000, 32'hAB00_0000);
    load(A4); resp(0, '0, A4, '0, '0, 0, '0, '0, "R6");
    check(core_rsp_rdata == 32'hAB22_9644, "R6", "merged word", 64'(core_rsp_rdata), 64'hAB22_9644);

    // R8: reset discards an outstanding tag
    load(A0);
    idle();
    run_model = 1'b0;
    tagq.delete();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) idle();
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) idle();
    run_model = 1'b1;
    load(A3);
    resp(0, '0, A0, '0, '0, 1, 4'b0010, A3, "R8");
    repeat (3) idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule